// File: doc/BRIEF.md
# Period and Rate Counter with Zero-Frequency Detect

This block measures a slow pulse signal, Z, against a reference tick enable and reports the result as one stored count. A mode input picks one of two measurements. In period mode the block counts reference ticks for as long as the synchronized Z level is high. It latches that count when Z goes low, then restarts from zero. In rate mode the block counts rising edges of Z inside a sample window. The window length is a time base, expressed in ticks, multiplied by a gate count. The count is latched at the end of every window.

The block raises a zero-frequency flag in two cases. In period mode it rises when the tick counter reaches its all-ones ceiling, because the counter saturates rather than wrapping. In rate mode it rises when a whole window passes with no Z edge. A 2-bit sequence number steps on every store. A host that polls slowly can compare successive values to tell how many results it missed. The present synchronized level of Z is also brought out as a status bit.

Top module: `freq_meas_core`

## Requirements
- R1: While and after synchronous reset, stored_count is 0, zero_freq is 0 and upd_seq is 0.
- R2: z_status equals the level z_in had two rising clock edges earlier.
- R3: In period mode (mode_rate = 0), on each falling edge of synchronized Z, stored_count takes the number of cycles in which synchronized Z was high and tick_en was 1; the next high phase counts again from zero.
- R4: Cycles with tick_en = 0 add nothing to the period count; a high phase with no ticks stores 0.
- R5: The period count stops at 2^CNT_W-1 instead of wrapping, and zero_freq rises as soon as that ceiling is reached, while Z is still high.
- R6: A period store of a value below the ceiling clears zero_freq; a store of the ceiling value stores all ones and leaves zero_freq at 1.
- R7: In rate mode (mode_rate = 1), a store happens once every time_base × gate_count tick-enabled cycles, with a value of 0 in either field treated as 1.
- R8: A rate-mode store holds the number of rising edges of synchronized Z seen during that window.
- R9: A rate-mode store of 0 sets zero_freq; a store of a non-zero count clears it.
- R10: upd_seq steps by exactly one, modulo 4 (0, 1, 2, 3, 0), on every store and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Reference tick enable, one cycle per tick |
| z_in | input | 1 | Asynchronous Z pulse input |
| mode_rate | input | 1 | 0 selects period mode, 1 selects rate mode |
| time_base | input | TB_W | Ticks per time-base step in rate mode |
| gate_count | input | GATE_W | Time-base steps per rate window |
| stored_count | output | CNT_W | Last latched measurement |
| zero_freq | output | 1 | Zero-frequency flag |
| z_status | output | 1 | Synchronized present level of Z |
| upd_seq | output | 2 | Rolling store sequence number |

## Verification
A change on z_in appears on z_status after the second rising edge. A period result is latched on the third edge after Z falls, and upd_seq and zero_freq move on that same edge. A rate result appears on the edge that closes the window. The bench drives inputs on falling edges and holds Z for an exact number of rising edges, so each expected period count equals the number of edges held. It then waits at least three edges before reading on a falling edge. For rate mode it first waits for a sequence change to align with a window boundary. It then places all its pulses well inside the following window and measures the distance between stores in cycles.

// File: rtl/freq_meas_pkg.sv
package freq_meas_pkg;

   typedef enum logic {
      MEAS_PERIOD = 1'b0,
      MEAS_RATE   = 1'b1
   } meas_mode_e;

   typedef struct packed {
      logic stb;
      logic flag;
   } store_evt_t;

endpackage

// File: rtl/fm_zsync.sv
module fm_zsync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic z_in,
   output logic z_lvl,
   output logic z_rise,
   output logic z_fall
);

   logic [STAGES-1:0] chain;
   logic              z_prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("fm_zsync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         chain  <= '0;
         z_prev <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], z_in};
         z_prev <= chain[STAGES-1];
      end
   end

   assign z_lvl  = chain[STAGES-1];
   assign z_rise = chain[STAGES-1] & ~z_prev;
   assign z_fall = ~chain[STAGES-1] & z_prev;

endmodule

// File: rtl/fm_period.sv
module fm_period #(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enable,
   input  logic             tick_en,
   input  logic             z_lvl,
   input  logic             z_fall,
   output logic             store_stb,
   output logic [CNT_W-1:0] store_val,
   output logic             store_sat,
   output logic             sat_hit
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - 1'b1;

   logic [CNT_W-1:0] ticks;
   logic             grow;

   assign grow = enable & z_lvl & tick_en & (ticks != CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         ticks <= '0;
      end else if (z_fall) begin
         ticks <= '0;
      end else if (grow) begin
         ticks <= ticks + 1'b1;
      end
   end

   assign store_stb = enable & z_fall;
   assign store_val = ticks;
   assign store_sat = (ticks == CNT_MAX);
   assign sat_hit   = grow & (ticks == CNT_PRE);

endmodule

// File: rtl/fm_rate.sv
module fm_rate #(
   parameter int unsigned CNT_W  = 24,
   parameter int unsigned TB_W   = 20,
   parameter int unsigned GATE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              enable,
   input  logic              tick_en,
   input  logic              z_rise,
   input  logic [TB_W-1:0]   time_base,
   input  logic [GATE_W-1:0] gate_count,
   output logic              store_stb,
   output logic [CNT_W-1:0]  store_val,
   output logic              store_empty
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [TB_W-1:0]   tb_cnt;
   logic [GATE_W-1:0] gate_cnt;
   logic [CNT_W-1:0]  pulses;
   logic [TB_W-1:0]   tb_last;
   logic [GATE_W-1:0] gate_last;
   logic              tb_end;
   logic              win_end;

   assign tb_last   = (time_base  == '0) ? '0 : time_base  - 1'b1;
   assign gate_last = (gate_count == '0) ? '0 : gate_count - 1'b1;
   assign tb_end    = enable & tick_en & (tb_cnt >= tb_last);
   assign win_end   = tb_end & (gate_cnt >= gate_last);

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         tb_cnt   <= '0;
         gate_cnt <= '0;
      end else if (tick_en) begin
         if (tb_end) begin
            tb_cnt   <= '0;
            gate_cnt <= win_end ? '0 : gate_cnt + 1'b1;
         end else begin
            tb_cnt <= tb_cnt + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !enable) begin
         pulses <= '0;
      end else if (win_end) begin
         pulses <= z_rise ? CNT_W'(1) : '0;
      end else if (z_rise && pulses != CNT_MAX) begin
         pulses <= pulses + 1'b1;
      end
   end

   assign store_stb   = win_end;
   assign store_val   = pulses;
   assign store_empty = (pulses == '0);

endmodule

// File: rtl/freq_meas_core.sv
module freq_meas_core
   import freq_meas_pkg::*;
#(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned TB_W        = 20,
   parameter int unsigned GATE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic              z_in,
   input  logic              mode_rate,
   input  logic [TB_W-1:0]   time_base,
   input  logic [GATE_W-1:0] gate_count,
   output logic [CNT_W-1:0]  stored_count,
   output logic              zero_freq,
   output logic              z_status,
   output logic [1:0]        upd_seq
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("freq_meas_core: CNT_W out of range 2..32");
      end
      if (TB_W < 1 || TB_W > 32) begin : g_bad_tb
         $error("freq_meas_core: TB_W out of range 1..32");
      end
      if (GATE_W < 1 || GATE_W > 16) begin : g_bad_gate
         $error("freq_meas_core: GATE_W out of range 1..16");
      end
   endgenerate

   meas_mode_e       mode;
   logic             z_lvl, z_rise, z_fall;
   logic             per_en, rate_en;
   logic             per_stb, per_sat, per_hit;
   logic [CNT_W-1:0] per_val;
   logic             rate_stb, rate_empty;
   logic [CNT_W-1:0] rate_val;
   store_evt_t       evt;
   logic [CNT_W-1:0] evt_val;

   assign mode    = meas_mode_e'(mode_rate);
   assign per_en  = (mode == MEAS_PERIOD);
   assign rate_en = (mode == MEAS_RATE);

   fm_zsync #(.STAGES(SYNC_STAGES)) i_zsync (
      .clk    (clk),
      .rst    (rst),
      .z_in   (z_in),
      .z_lvl  (z_lvl),
      .z_rise (z_rise),
      .z_fall (z_fall)
   );

   fm_period #(.CNT_W(CNT_W)) i_period (
      .clk       (clk),
      .rst       (rst),
      .enable    (per_en),
      .tick_en   (tick_en),
      .z_lvl     (z_lvl),
      .z_fall    (z_fall),
      .store_stb (per_stb),
      .store_val (per_val),
      .store_sat (per_sat),
      .sat_hit   (per_hit)
   );

   fm_rate #(.CNT_W(CNT_W), .TB_W(TB_W), .GATE_W(GATE_W)) i_rate (
      .clk         (clk),
      .rst         (rst),
      .enable      (rate_en),
      .tick_en     (tick_en),
      .z_rise      (z_rise),
      .time_base   (time_base),
      .gate_count  (gate_count),
      .store_stb   (rate_stb),
      .store_val   (rate_val),
      .store_empty (rate_empty)
   );

   always_comb begin
      evt     = '0;
      evt_val = '0;
      if (per_stb) begin
         evt.stb  = 1'b1;
         evt.flag = per_sat;
         evt_val  = per_val;
      end else if (rate_stb) begin
         evt.stb  = 1'b1;
         evt.flag = rate_empty;
         evt_val  = rate_val;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         stored_count <= '0;
         zero_freq    <= 1'b0;
         upd_seq      <= 2'd0;
      end else if (evt.stb) begin
         stored_count <= evt_val;
         zero_freq    <= evt.flag;
         upd_seq      <= upd_seq + 2'd1;
      end else if (per_hit) begin
         zero_freq <= 1'b1;
      end
   end

   assign z_status = z_lvl;

endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
   parameter int unsigned CNT_W       = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             z_in,
   input logic             mode_rate,
   input logic [CNT_W-1:0] stored_count,
   input logic             zero_freq,
   input logic             z_status,
   input logic [1:0]       upd_seq
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [1:0] age;

   always_ff @(posedge clk) begin
      if (rst) age <= 2'd0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         a_r2_zstatus_delay: assert property (@(posedge clk) disable iff (rst)
            (age >= 2'd2) |-> (z_status == $past(z_in, 2)));
      end
   endgenerate

   a_r10_seq_step: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && upd_seq != $past(upd_seq)) |-> (upd_seq == $past(upd_seq) + 2'd1));

   a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && upd_seq != $past(upd_seq) && stored_count != '0 && stored_count != CNT_MAX)
      |-> !zero_freq);

   a_r5_sat_flag: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && upd_seq != $past(upd_seq) && !mode_rate && stored_count == CNT_MAX)
      |-> zero_freq);

   a_r9_empty_flag: assert property (@(posedge clk) disable iff (rst)
      (age != 2'd0 && upd_seq != $past(upd_seq) && mode_rate && stored_count == '0)
      |-> zero_freq);

endmodule

bind freq_meas_core fm_checker #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_fm_checker (
   .clk          (clk),
   .rst          (rst),
   .z_in         (z_in),
   .mode_rate    (mode_rate),
   .stored_count (stored_count),
   .zero_freq    (zero_freq),
   .z_status     (z_status),
   .upd_seq      (upd_seq)
);

// File: tb/test_freq_meas_core.sv
`timescale 1ns/1ps
module test_freq_meas_core;

   localparam int CNT_W  = 8;
   localparam int TB_W   = 12;
   localparam int GATE_W = 4;
   localparam int WIN_TB = 10;
   localparam int WIN_GT = 5;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              tick_en = 1'b1;
   logic              z_in = 1'b0;
   logic              mode_rate = 1'b0;
   logic [TB_W-1:0]   time_base = TB_W'(WIN_TB);
   logic [GATE_W-1:0] gate_count = GATE_W'(WIN_GT);
   logic [CNT_W-1:0]  stored_count;
   logic              zero_freq;
   logic              z_status;
   logic [1:0]        upd_seq;

   int checks = 0;
   int failures = 0;
   logic [1:0] exp_seq = 2'd0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   freq_meas_core #(.CNT_W(CNT_W), .TB_W(TB_W), .GATE_W(GATE_W)) i_freq_meas_core (
      .clk          (clk),
      .rst          (rst),
      .tick_en      (tick_en),
      .z_in         (z_in),
      .mode_rate    (mode_rate),
      .time_base    (time_base),
      .gate_count   (gate_count),
      .stored_count (stored_count),
      .zero_freq    (zero_freq),
      .z_status     (z_status),
      .upd_seq      (upd_seq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // period pulse: Z high for exactly n rising edges, result read 4 edges after the fall
   task automatic z_pulse(input int n);
      @(negedge clk);
      z_in = 1'b1;
      edges(n);
      z_in = 1'b0;
      edges(4);
   endtask

   task automatic wait_store(input int limit, output int cyc);
      logic [1:0] s0;
      s0 = upd_seq;
      cyc = 0;
      while (upd_seq == s0 && cyc < limit) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic t_reset;
      rst = 1'b1;
      edges(3);
      chk(stored_count == '0, "R1 stored_count", int'(stored_count), 0);
      chk(zero_freq == 1'b0, "R1 zero_freq", int'(zero_freq), 0);
      chk(upd_seq == 2'd0, "R1 upd_seq", int'(upd_seq), 0);
      rst = 1'b0;
      exp_seq = 2'd0;
      edges(2);
   endtask

   task automatic t_zstatus;
      z_in = 1'b1;
      edges(1);
      chk(z_status == 1'b0, "R2 z_status after one edge", int'(z_status), 0);
      edges(1);
      chk(z_status == 1'b1, "R2 z_status after two edges", int'(z_status), 1);
      z_in = 1'b0;
      edges(4);
      exp_seq = exp_seq + 2'd1;
      chk(upd_seq == exp_seq, "R10 seq after status pulse", int'(upd_seq), int'(exp_seq));
   endtask

   task automatic t_period(input int n);
      z_pulse(n);
      exp_seq = exp_seq + 2'd1;
      chk(stored_count == CNT_W'(n), "R3 period count", int'(stored_count), n);
      chk(zero_freq == 1'b0, "R6 flag after short period", int'(zero_freq), 0);
      chk(upd_seq == exp_seq, "R10 seq after period store", int'(upd_seq), int'(exp_seq));
   endtask

   task automatic t_tick_gate;
      tick_en = 1'b0;
      z_pulse(12);
      tick_en = 1'b1;
      exp_seq = exp_seq + 2'd1;
      chk(stored_count == '0, "R4 no ticks stores zero", int'(stored_count), 0);
      chk(upd_seq == exp_seq, "R10 seq after gated store", int'(upd_seq), int'(exp_seq));
   endtask

   task automatic t_saturate;
      logic [1:0] s0;
      s0 = upd_seq;
      z_in = 1'b1;
      edges(280);
      chk(zero_freq == 1'b1, "R5 flag while Z high", int'(zero_freq), 1);
      chk(upd_seq == s0, "R10 no step on saturation", int'(upd_seq), int'(s0));
      z_in = 1'b0;
      edges(4);
      exp_seq = exp_seq + 2'd1;
      chk(stored_count == {CNT_W{1'b1}}, "R5 saturated value", int'(stored_count), (1 << CNT_W) - 1);
      chk(zero_freq == 1'b1, "R6 flag kept on saturated store", int'(zero_freq), 1);
      z_pulse(20);
      exp_seq = exp_seq + 2'd1;
      chk(stored_count == CNT_W'(20), "R3 period after saturation", int'(stored_count), 20);
      chk(zero_freq == 1'b0, "R6 flag cleared by valid period", int'(zero_freq), 0);
   endtask

   task automatic t_seq_wrap;
      logic [1:0] s0;
      s0 = upd_seq;
      for (int i = 0; i < 4; i++) z_pulse(3 + i);
      exp_seq = exp_seq + 2'd0;
      chk(upd_seq == s0, "R10 wrap after four stores", int'(upd_seq), int'(s0));
      chk(stored_count == CNT_W'(6), "R3 last of four", int'(stored_count), 6);
   endtask

   task automatic t_rate;
      int cyc;
      mode_rate = 1'b1;
      wait_store(200, cyc);
      exp_seq = exp_seq + 2'd1;
      chk(cyc <= WIN_TB * WIN_GT + 2, "R7 first window reached", cyc, WIN_TB * WIN_GT);
      for (int k = 0; k < 3; k++) begin
         z_in = 1'b1;
         edges(4);
         z_in = 1'b0;
         edges(4);
      end
      wait_store(200, cyc);
      exp_seq = exp_seq + 2'd1;
      chk(stored_count == CNT_W'(3), "R8 rate edges counted", int'(stored_count), 3);
      chk(zero_freq == 1'b0, "R9 flag clear with edges", int'(zero_freq), 0);
      wait_store(200, cyc);
      exp_seq = exp_seq + 2'd1;
      chk(cyc == WIN_TB * WIN_GT, "R7 window length", cyc, WIN_TB * WIN_GT);
      chk(stored_count == '0, "R8 empty window", int'(stored_count), 0);
      chk(zero_freq == 1'b1, "R9 flag on empty window", int'(zero_freq), 1);
      chk(upd_seq == exp_seq, "R10 seq in rate mode", int'(upd_seq), int'(exp_seq));
      gate_count = '0;
      time_base  = TB_W'(7);
      wait_store(200, cyc);
      wait_store(200, cyc);
      exp_seq = exp_seq + 2'd2;
      chk(cyc == 7, "R7 zero gate acts as one", cyc, 7);
      mode_rate = 1'b0;
      edges(2);
   endtask

   initial begin
      t_reset();
      t_zstatus();
      t_period(7);
      t_period(13);
      t_tick_gate();
      t_saturate();
      t_seq_wrap();
      t_rate();
      chk(upd_seq == exp_seq, "R10 final sequence", int'(upd_seq), int'(exp_seq));
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule